// File: doc/BRIEF.md
# Calendar Real-Time Clock with BCD Year

This block keeps wall-clock time in calendar form. One 29-bit word holds the
second, minute, hour, weekday, day of month and month fields. A separate 16-bit
register holds the year as four BCD digits: two for the year within the century
and two for the century itself. A one-second strobe from outside advances the
time. Every carry is resolved in the same cycle: seconds into minutes, minutes
into hours, hours into day and weekday, day into month, and month into the
decimal year. The carry from day into month follows each month's length and the
Gregorian leap-year rule.

Software sets the clock in two steps. It first writes the year into a staging
register. It then writes the time word, and that write commits the time and the
staged year to the running counters together. Two match registers, one for the
time word and one for the year, form an alarm. The alarm compares every field,
and the weekday is compared exactly. The alarm flag goes high once when the
running value becomes equal to the match value. It stays high until software
clears it.

Top module: `cal_rtc`

## Requirements
- R1: After a synchronous reset the clock reads time word 0x0212_0000 (month 1, day 1, weekday 1, 00:00:00), year 0x2000, and the alarm is low.
- R2: A write with `wr_sel`=0 loads `wr_data[28:0]` into the time counter and copies the staged year into the year counter; both show on the outputs after that clock edge. Bits 31:29 of the data are ignored and `time_q[31:29]` always reads 0. Field positions: seconds 5:0, minutes 11:6, hours 16:12, weekday 19:17, day 24:20, month 28:25.
- R3: A write with `wr_sel`=2 stores `wr_data[15:0]` only in the staging register. `year_q` does not change until the next time-load write.
- R4: Each cycle with `sec_tick` high advances the seconds field by one. Seconds 59 wraps to 0 and carries into minutes. Minutes 59 wraps to 0 and carries into hours. With `sec_tick` low, the time and the year hold.
- R5: Hours 23 wraps to 0 and advances the day of month and the weekday. The weekday counts 1 to 7 (1 = Sunday) and wraps from 7 to 1.
- R6: A day carry past the last day of the month sets the day to 1 and advances the month. Months 4, 6, 9 and 11 have 30 days. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days.
- R7: February has 29 days when the year is a leap year and 28 days otherwise. A year is a leap year when it is divisible by 4, except that a year ending in 00 must have a century divisible by 4 (1900 is not a leap year, 2000 is).
- R8: A month carry past 12 sets the month to 1 and adds one to the BCD year, with decimal carry from the low byte (bits 7:0) into the century byte (bits 15:8). For example 0x2099 becomes 0x2100 and 0x1999 becomes 0x2000.
- R9: The alarm is raised one cycle after the running time and year first become equal to the match time (`wr_sel`=1, bits 28:0) and the match year (`wr_sel`=3). All fields are compared, so a differing weekday or year gives no alarm.
- R10: Once raised, the alarm stays high until a write with `wr_sel`=4, which clears it after that edge. A clear while the time still equals the match does not raise the alarm again.
- R11: When a time-load write and `sec_tick` fall in the same cycle, the loaded value wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 time load, 1 time match, 2 year stage, 3 year match, 4 alarm clear |
| wr_data | input | 32 | Write data |
| time_q | output | 32 | Running packed time word |
| year_q | output | 16 | Running BCD year |
| alarm_q | output | 1 | Sticky alarm flag |

## Verification
Writes and ticks change `time_q` and `year_q` at the rising edge that samples them. The alarm flag changes one edge later, because the equality is registered before it sets the flag. The driver pushes the expected time, year and alarm into a queue right after the edge that applies a stimulus. The monitor compares them at the next falling edge. An idle cycle is queued after any tick that should reach the match value, so that the alarm's extra cycle of latency is checked on its own at the correct edge.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  // Packed time word, most significant field first; seconds occupy the LSBs.
  typedef struct packed {
    logic [3:0] mon;
    logic [4:0] day;
    logic [2:0] wday;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam int TIME_W  = $bits(cal_time_t);
  localparam int WORD_W  = 32;
  localparam int SEL_W   = 3;

  localparam logic [5:0] SEC_MAX  = 6'd59;
  localparam logic [5:0] MIN_MAX  = 6'd59;
  localparam logic [4:0] HR_MAX   = 5'd23;
  localparam logic [2:0] WDAY_MAX = 3'd7;
  localparam logic [3:0] MON_MAX  = 4'd12;

  typedef enum logic [SEL_W-1:0] {
    SEL_TIME_LOAD  = 3'd0,
    SEL_TIME_MATCH = 3'd1,
    SEL_YEAR_STAGE = 3'd2,
    SEL_YEAR_MATCH = 3'd3,
    SEL_ALARM_CLR  = 3'd4
  } wr_sel_e;

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [3:0]  mon,
  input  logic [15:0] year_bcd,
  output logic [4:0]  last_day
);

  // A two-digit BCD value 10*t+u is divisible by 4 exactly when 2*t+u is.
  function automatic logic pair_div4(input logic [7:0] pair);
    logic [4:0] s;
    s = {pair[7:4], 1'b0} + {1'b0, pair[3:0]};
    return s[1:0] == 2'b00;
  endfunction

  logic leap;

  always_comb begin
    if (year_bcd[7:0] != 8'h00) leap = pair_div4(year_bcd[7:0]);
    else                        leap = pair_div4(year_bcd[15:8]);
  end

  always_comb begin
    case (mon)
      4'd2:                      last_day = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   last_day = 5'd30;
      default:                   last_day = 5'd31;
    endcase
  end

endmodule

// File: rtl/cal_bcd_inc.sv
module cal_bcd_inc #(
  parameter int NDIG = 4
) (
  input  logic [4*NDIG-1:0] d,
  input  logic              inc,
  output logic [4*NDIG-1:0] q
);

  logic [NDIG-1:0] cy;
  assign cy[0] = inc;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] dv;
    logic       top;
    assign dv  = d[4*i +: 4];
    assign top = (dv >= 4'd9);
    assign q[4*i +: 4] = cy[i] ? (top ? 4'd0 : dv + 4'd1) : dv;
    if (i < NDIG-1) begin : g_cy
      assign cy[i+1] = cy[i] && top;
    end
  end

endmodule

// File: rtl/cal_advance.sv
module cal_advance
  import cal_rtc_pkg::*;
#(
  parameter int YEAR_DIGITS = 4
) (
  input  cal_time_t              cur,
  input  logic [4*YEAR_DIGITS-1:0] year,
  output cal_time_t              nxt,
  output logic [4*YEAR_DIGITS-1:0] nxt_year
);

  logic [4:0] last_day;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  cal_month_len u_len (
    .mon      (cur.mon),
    .year_bcd (year[15:0]),
    .last_day (last_day)
  );

  assign c_min = (cur.sec >= SEC_MAX);
  assign c_hr  = c_min && (cur.min >= MIN_MAX);
  assign c_day = c_hr  && (cur.hr  >= HR_MAX);
  assign c_mon = c_day && (cur.day >= last_day);
  assign c_yr  = c_mon && (cur.mon >= MON_MAX);

  always_comb begin
    nxt.sec  = c_min ? 6'd0 : cur.sec + 6'd1;
    nxt.min  = c_min ? (c_hr ? 6'd0 : cur.min + 6'd1) : cur.min;
    nxt.hr   = c_hr  ? (c_day ? 5'd0 : cur.hr + 5'd1) : cur.hr;
    nxt.wday = c_day ? ((cur.wday >= WDAY_MAX) ? 3'd1 : cur.wday + 3'd1) : cur.wday;
    nxt.day  = c_day ? (c_mon ? 5'd1 : cur.day + 5'd1) : cur.day;
    nxt.mon  = c_mon ? (c_yr ? 4'd1 : cur.mon + 4'd1) : cur.mon;
  end

  cal_bcd_inc #(.NDIG(YEAR_DIGITS)) u_year (
    .d   (year),
    .inc (c_yr),
    .q   (nxt_year)
  );

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int                   YEAR_DIGITS = 4,
  parameter logic [TIME_W-1:0]    RESET_TIME  = 29'h0212_0000,
  parameter logic [4*YEAR_DIGITS-1:0] RESET_YEAR = 16'h2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sec_tick,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [WORD_W-1:0]        time_q,
  output logic [4*YEAR_DIGITS-1:0] year_q,
  output logic                     alarm_q
);

  localparam int YEAR_W = 4 * YEAR_DIGITS;

  cal_time_t         cur, m_time, nxt;
  logic [YEAR_W-1:0] year_r, year_stage, m_year, nxt_year;
  logic              eq, eq_d, hit, alarm_r;
  logic              ld_time, ld_mtime, ld_ystage, ld_myear, clr;
  logic              unused_hi;

  assign unused_hi = ^wr_data[WORD_W-1:TIME_W];

  assign ld_time   = wr_en && (wr_sel == SEL_TIME_LOAD);
  assign ld_mtime  = wr_en && (wr_sel == SEL_TIME_MATCH);
  assign ld_ystage = wr_en && (wr_sel == SEL_YEAR_STAGE);
  assign ld_myear  = wr_en && (wr_sel == SEL_YEAR_MATCH);
  assign clr       = wr_en && (wr_sel == SEL_ALARM_CLR);

  cal_advance #(.YEAR_DIGITS(YEAR_DIGITS)) u_adv (
    .cur      (cur),
    .year     (year_r),
    .nxt      (nxt),
    .nxt_year (nxt_year)
  );

  // Running counters: load takes priority over the second strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= cal_time_t'(RESET_TIME);
      year_r <= RESET_YEAR;
    end else if (ld_time) begin
      cur    <= cal_time_t'(wr_data[TIME_W-1:0]);
      year_r <= year_stage;
    end else if (sec_tick) begin
      cur    <= nxt;
      year_r <= nxt_year;
    end
  end

  // Staging and match registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      year_stage <= RESET_YEAR;
      m_time     <= '0;
      m_year     <= '0;
    end else begin
      if (ld_ystage) year_stage <= wr_data[YEAR_W-1:0];
      if (ld_mtime)  m_time     <= cal_time_t'(wr_data[TIME_W-1:0]);
      if (ld_myear)  m_year     <= wr_data[YEAR_W-1:0];
    end
  end

  // Alarm: raised on the first cycle of equality, held until cleared.
  assign eq  = (cur == m_time) && (year_r == m_year);
  assign hit = eq && !eq_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_d    <= 1'b0;
      alarm_r <= 1'b0;
    end else begin
      eq_d    <= eq;
      alarm_r <= hit || (alarm_r && !clr);
    end
  end

  assign time_q  = {{(WORD_W-TIME_W){1'b0}}, cur};
  assign year_q  = year_r;
  assign alarm_q = alarm_r;

  // R4
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !ld_time && cur.sec < SEC_MAX) |=> (cur.sec == $past(cur.sec) + 6'd1));

  // R3
  year_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_time && !sec_tick) |=> $stable(year_r));

  // R2
  load_commit_chk: assert property (@(posedge clk) disable iff (rst)
    ld_time |=> (time_q[TIME_W-1:0] == $past(wr_data[TIME_W-1:0])));

  // R9
  alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> alarm_q);

  // R10
  alarm_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !alarm_q);

  // R10
  alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_q && !clr) |=> alarm_q);

endmodule

// File: tb/cal_rtc_bench.sv
`timescale 1ns/1ps
module cal_rtc_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] time_q;
  logic [15:0] year_q;
  logic        alarm_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0] t;
    logic [15:0] y;
    logic        a;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  cal_rtc u_cal_rtc (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .time_q(time_q), .year_q(year_q), .alarm_q(alarm_q)
  );

  function automatic logic [31:0] pk(int mo, int d, int w, int h, int mi, int s);
    return (mo << 25) | (d << 20) | (w << 17) | (h << 12) | (mi << 6) | s;
  endfunction

  // Driver: apply one cycle of stimulus, queue what is due after that edge.
  task automatic op(input bit we, input bit [2:0] sel, input bit [31:0] d,
                    input bit tk, input bit [31:0] et, input bit [15:0] ey,
                    input bit ea, input string tag);
    wr_en = we; wr_sel = sel; wr_data = d; sec_tick = tk;
    @(posedge clk);
    q_exp.push_back('{t: et, y: ey, a: ea});
    q_tag.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0; wr_data = 32'd0;
  endtask

  // Monitor: compare at the falling edge after each queued stimulus.
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      exp_t  e;
      string tg;
      e  = q_exp.pop_front();
      tg = q_tag.pop_front();
      n_run++;
      if (time_q !== e.t || year_q !== e.y || alarm_q !== e.a) begin
        n_fail++;
        $display("FAIL %s: time=%h year=%h alarm=%b expected time=%h year=%h alarm=%b",
                 tg, time_q, year_q, alarm_q, e.t, e.y, e.a);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    op(0, 0, 0, 0, 32'h0212_0000, 16'h2000, 0, "R1 reset state");
    op(1, 2, 32'h2023, 0, 32'h0212_0000, 16'h2000, 0, "R3 staged year not visible");
    op(1, 0, pk(3,15,4,10,20,30), 0, pk(3,15,4,10,20,30), 16'h2023, 0, "R2 load commits time and year");
    op(0, 0, 0, 1, pk(3,15,4,10,20,31), 16'h2023, 0, "R4 tick advances seconds");
    op(0, 0, 0, 0, pk(3,15,4,10,20,31), 16'h2023, 0, "R4 hold without tick");
    op(1, 0, 32'hE000_0000 | pk(5,10,2,10,59,59), 0, pk(5,10,2,10,59,59), 16'h2023, 0, "R2 top bits ignored");
    op(0, 0, 0, 1, pk(5,10,2,11,0,0), 16'h2023, 0, "R4 minute and hour carry");

    op(1, 0, pk(4,30,7,23,59,59), 0, pk(4,30,7,23,59,59), 16'h2023, 0, "R2 load");
    op(0, 0, 0, 1, pk(5,1,1,0,0,0), 16'h2023, 0, "R6 30-day month end, R5 weekday 7 to 1");
    op(1, 0, pk(1,30,3,23,59,59), 0, pk(1,30,3,23,59,59), 16'h2023, 0, "R2 load");
    op(0, 0, 0, 1, pk(1,31,4,0,0,0), 16'h2023, 0, "R5 day and weekday advance");
    op(0, 0, 0, 0, pk(1,31,4,0,0,0), 16'h2023, 0, "R4 hold");
    op(1, 0, pk(1,31,4,23,59,59), 0, pk(1,31,4,23,59,59), 16'h2023, 0, "R2 load");
    op(0, 0, 0, 1, pk(2,1,5,0,0,0), 16'h2023, 0, "R6 31-day month end");

    op(1, 2, 32'h2024, 0, pk(2,1,5,0,0,0), 16'h2023, 0, "R3 staging write");
    op(1, 0, pk(2,28,4,23,59,59), 0, pk(2,28,4,23,59,59), 16'h2024, 0, "R2 load leap year");
    op(0, 0, 0, 1, pk(2,29,5,0,0,0), 16'h2024, 0, "R7 leap Feb 29");
    op(1, 0, pk(2,29,5,23,59,59), 0, pk(2,29,5,23,59,59), 16'h2024, 0, "R2 load");
    op(0, 0, 0, 1, pk(3,1,6,0,0,0), 16'h2024, 0, "R7 leap Feb 29 to Mar 1");
    op(1, 2, 32'h2023, 0, pk(3,1,6,0,0,0), 16'h2024, 0, "R3 staging write");
    op(1, 0, pk(2,28,3,23,59,59), 0, pk(2,28,3,23,59,59), 16'h2023, 0, "R2 load");
    op(0, 0, 0, 1, pk(3,1,4,0,0,0), 16'h2023, 0, "R7 common Feb 28 to Mar 1");
    op(1, 2, 32'h1900, 0, pk(3,1,4,0,0,0), 16'h2023, 0, "R3 staging write");
    op(1, 0, pk(2,28,4,23,59,59), 0, pk(2,28,4,23,59,59), 16'h1900, 0, "R2 load");
    op(0, 0, 0, 1, pk(3,1,5,0,0,0), 16'h1900, 0, "R7 1900 not leap");
    op(1, 2, 32'h2000, 0, pk(3,1,5,0,0,0), 16'h1900, 0, "R3 staging write");
    op(1, 0, pk(2,28,2,23,59,59), 0, pk(2,28,2,23,59,59), 16'h2000, 0, "R2 load");
    op(0, 0, 0, 1, pk(2,29,3,0,0,0), 16'h2000, 0, "R7 2000 is leap");

    op(1, 2, 32'h2099, 0, pk(2,29,3,0,0,0), 16'h2000, 0, "R3 staging write");
    op(1, 0, pk(12,31,5,23,59,59), 0, pk(12,31,5,23,59,59), 16'h2099, 0, "R2 load");
    op(0, 0, 0, 1, pk(1,1,6,0,0,0), 16'h2100, 0, "R8 year carry into century");
    op(1, 2, 32'h1999, 0, pk(1,1,6,0,0,0), 16'h2100, 0, "R3 staging write");
    op(1, 0, pk(12,31,7,23,59,59), 0, pk(12,31,7,23,59,59), 16'h1999, 0, "R2 load");
    op(0, 0, 0, 1, pk(1,1,1,0,0,0), 16'h2000, 0, "R8 1999 to 2000");

    op(1, 0, pk(7,4,3,12,0,0), 1, pk(7,4,3,12,0,0), 16'h1999, 0, "R11 load beats tick");

    op(1, 3, 32'h2024, 0, pk(7,4,3,12,0,0), 16'h1999, 0, "R9 set match year");
    op(1, 1, pk(6,1,2,0,0,1), 0, pk(7,4,3,12,0,0), 16'h1999, 0, "R9 set match time");
    op(1, 2, 32'h2024, 0, pk(7,4,3,12,0,0), 16'h1999, 0, "R3 staging write");
    op(1, 0, pk(6,1,2,0,0,0), 0, pk(6,1,2,0,0,0), 16'h2024, 0, "R2 load before match");
    op(0, 0, 0, 1, pk(6,1,2,0,0,1), 16'h2024, 0, "R9 alarm not yet on match edge");
    op(0, 0, 0, 0, pk(6,1,2,0,0,1), 16'h2024, 1, "R9 alarm raised");
    op(0, 0, 0, 0, pk(6,1,2,0,0,1), 16'h2024, 1, "R10 alarm held");
    op(1, 4, 0, 0, pk(6,1,2,0,0,1), 16'h2024, 0, "R10 clear while equal");
    op(0, 0, 0, 0, pk(6,1,2,0,0,1), 16'h2024, 0, "R10 no re-raise");

    op(1, 1, pk(6,1,3,0,0,1), 0, pk(6,1,2,0,0,1), 16'h2024, 0, "R9 weekday 3 match");
    op(1, 0, pk(6,1,2,0,0,0), 0, pk(6,1,2,0,0,0), 16'h2024, 0, "R2 load");
    op(0, 0, 0, 1, pk(6,1,2,0,0,1), 16'h2024, 0, "R4 tick");
    op(0, 0, 0, 0, pk(6,1,2,0,0,1), 16'h2024, 0, "R9 weekday mismatch no alarm");

    op(1, 3, 32'h2025, 0, pk(6,1,2,0,0,1), 16'h2024, 0, "R9 match year 2025");
    op(1, 1, pk(6,1,2,0,0,1), 0, pk(6,1,2,0,0,1), 16'h2024, 0, "R9 match time");
    op(1, 0, pk(6,1,2,0,0,0), 0, pk(6,1,2,0,0,0), 16'h2024, 0, "R2 load");
    op(0, 0, 0, 1, pk(6,1,2,0,0,1), 16'h2024, 0, "R4 tick");
    op(0, 0, 0, 0, pk(6,1,2,0,0,1), 16'h2024, 0, "R9 year mismatch no alarm");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule